// File: doc/BRIEF.md
# Two-Wire Slave with Pointer-Addressed Register Bank

This block is a two-wire serial slave that sits on an open-drain clock/data bus and gives a bus master access to a small bank of 8-bit registers. Both bus lines are sampled by the system clock through synchronisers. START and STOP conditions and SCL edges are found on the synchronised levels, so the bus logic runs entirely in the system clock domain. The only bus output is a pull-low enable for SDA.

A transaction opens with a START, followed by a 7-bit device address and a direction bit. In a write, the first data byte selects a register by loading the pointer, and an optional second byte is stored in the selected register. A read returns the selected register once. After that the slave lets go of the bus until the master ends the transaction.

A second port lets on-chip logic read and write the same bank directly.

Top module: `twi_ptr_slave`

## Requirements
- R1: A START (SDA falls while SCL is high) begins address reception from any state, including a repeated START in mid-transaction. A STOP (SDA rises while SCL is high) returns the slave to idle with SDA released.
- R2: After START the slave takes eight bits, MSB first: the 7-bit device address, then a direction bit (0 = write, 1 = read). When the address equals parameter DEV_ADDR, SDA is pulled low for the ninth clock.
- R3: On an address mismatch the slave never pulls SDA low until the next START, and neither the pointer nor any register changes.
- R4: SDA is sampled on SCL rising edges. The SDA output changes only while SCL is low, so it is stable across every SCL high phase.
- R5: The first data byte of a write is acknowledged. Its low PTR_W bits load the pointer, which keeps its value across transactions.
- R6: A second data byte in a write is acknowledged and stored in the register the pointer selects. The pointer does not change.
- R7: Every further data byte in the same write is answered with NACK (SDA released on the ninth clock) and changes no register.
- R8: A read shifts out the selected register MSB first, with bit 7 driven after the address acknowledge. After those eight bits SDA stays released for the rest of the transaction, whatever the master answers, so later clocks read as 1s.
- R9: The direction bit holds for the whole transaction. A repeated START abandons the transaction and starts a new address phase, and the pointer set before it is used by a following read.
- R10: The direct port writes the register at ext_addr_i when ext_we_i is high, and ext_rdata_o shows that register combinationally. Values written over the bus are visible there, and values written there are returned by bus reads.
- R11: After reset SDA is released, the pointer is 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Level of the serial clock line |
| sda_i | input | 1 | Level of the serial data line |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| ext_we_i | input | 1 | Direct-port write strobe |
| ext_addr_i | input | PTR_W | Direct-port register index |
| ext_wdata_i | input | 8 | Direct-port write data |
| ext_rdata_o | output | 8 | Direct-port read data |

## Verification
A wrong protocol state shows up on SDA within one byte. It appears as a missing or extra acknowledge on the ninth clock, or as read bits shifted or driven into the SCL high phase. A wrong pointer or a stray register write stays hidden until that register is read, so every bus write is followed by a readback through the direct port or over the bus. Random traffic mixes bus and direct-port writes with reads checked against a reference model. Directed cases cover the NACK paths, mismatched addresses and repeated STARTs.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = 4;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_WRITE,
        ST_READ,
        ST_HOLD
    } fsm_st_e;

    typedef enum logic [1:0] {
        WB_PTR,
        WB_DATA,
        WB_EXTRA
    } wbyte_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_hit(input byte_t frame, input logic [6:0] dev);
        return frame[BYTE_W-1:1] == dev;
    endfunction

endpackage

// File: rtl/twi_sync_edge.sv
module twi_sync_edge
    import twi_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_now;
    logic              sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_now = scl_pipe[STAGES-1];
    assign sda_now = sda_pipe[STAGES-1];

    always_comb begin
        ev_o.scl      = scl_now;
        ev_o.sda      = sda_now;
        ev_o.scl_rise = scl_now & ~scl_d;
        ev_o.scl_fall = ~scl_now & scl_d;
        ev_o.start    = scl_now & scl_d & sda_d & ~sda_now;
        ev_o.stop     = scl_now & scl_d & ~sda_d & sda_now;
    end

endmodule

// File: rtl/twi_regbank.sv
module twi_regbank
    import twi_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  byte_t             bus_wdata,
    output byte_t             bus_rdata,
    input  logic              ext_we,
    input  logic [ADDR_W-1:0] ext_addr,
    input  byte_t             ext_wdata,
    output byte_t             ext_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    byte_t mem [DEPTH];

    // The bus port takes priority when both ports hit one register together.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (bus_we && bus_addr == ADDR_W'(i)) begin
                    mem[i] <= bus_wdata;
                end else if (ext_we && ext_addr == ADDR_W'(i)) begin
                    mem[i] <= ext_wdata;
                end
            end
        end
    end

    assign bus_rdata = mem[bus_addr];
    assign ext_rdata = mem[ext_addr];

endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
    import twi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4C,
    parameter int         PTR_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  byte_t            rdata,
    output logic             sda_oe,
    output logic [PTR_W-1:0] ptr,
    output logic             wr_en,
    output byte_t            wr_data,
    output fsm_st_e          state
);

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W);

    logic [BIT_CNT_W-1:0] bit_cnt;
    byte_t                rx_sh;
    byte_t                tx_sh;
    logic                 rd_dir;
    wbyte_e               wbyte;
    logic                 byte_done;

    assign byte_done = ev.scl_fall && (bit_cnt == LAST_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            rd_dir  <= 1'b0;
            wbyte   <= WB_PTR;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                    end
                    ST_ADDR: begin
                        if (ev.scl_rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], ev.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_done) begin
                            if (addr_hit(rx_sh, DEV_ADDR)) begin
                                sda_oe <= 1'b1;
                                rd_dir <= rx_sh[0];
                                wbyte  <= WB_PTR;
                                state  <= ST_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_WRITE: begin
                        if (ev.scl_rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], ev.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_done) begin
                            state <= ST_ACK;
                            unique case (wbyte)
                                WB_PTR: begin
                                    ptr    <= rx_sh[PTR_W-1:0];
                                    sda_oe <= 1'b1;
                                    wbyte  <= WB_DATA;
                                end
                                WB_DATA: begin
                                    wr_en   <= 1'b1;
                                    wr_data <= rx_sh;
                                    sda_oe  <= 1'b1;
                                    wbyte   <= WB_EXTRA;
                                end
                                default: begin
                                    sda_oe <= 1'b0;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_fall) begin
                            bit_cnt <= '0;
                            if (rd_dir) begin
                                state  <= ST_READ;
                                tx_sh  <= rdata;
                                sda_oe <= ~rdata[BYTE_W-1];
                            end else begin
                                state  <= ST_WRITE;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_READ: begin
                        if (ev.scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_done) begin
                            sda_oe <= 1'b0;
                            state  <= ST_HOLD;
                        end else if (ev.scl_fall) begin
                            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~tx_sh[BYTE_W-2];
                        end
                    end
                    ST_HOLD: begin
                    end
                    default: begin
                        state  <= ST_IDLE;
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/twi_ptr_slave.sv
module twi_ptr_slave
    import twi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h4C,
    parameter int         PTR_W       = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    input  logic             ext_we_i,
    input  logic [PTR_W-1:0] ext_addr_i,
    input  logic [7:0]       ext_wdata_i,
    output logic [7:0]       ext_rdata_o
);

    bus_ev_t          ev;
    byte_t            bus_rdata;
    logic [PTR_W-1:0] ptr;
    logic             bus_we;
    byte_t            bus_wdata;
    fsm_st_e          fsm_state;

    twi_sync_edge #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .ev_o (ev)
    );

    twi_slave_fsm #(
        .DEV_ADDR(DEV_ADDR),
        .PTR_W   (PTR_W)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .rdata  (bus_rdata),
        .sda_oe (sda_oe_o),
        .ptr    (ptr),
        .wr_en  (bus_we),
        .wr_data(bus_wdata),
        .state  (fsm_state)
    );

    twi_regbank #(
        .ADDR_W(PTR_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .bus_we   (bus_we),
        .bus_addr (ptr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .ext_we   (ext_we_i),
        .ext_addr (ext_addr_i),
        .ext_wdata(ext_wdata_i),
        .ext_rdata(ext_rdata_o)
    );

endmodule

// File: rtl/twi_ptr_slave_chk.sv
module twi_ptr_slave_chk
    import twi_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst,
    input bus_ev_t          ev,
    input logic             sda_oe_o,
    input fsm_st_e          fsm_state,
    input logic             bus_we,
    input logic [PTR_W-1:0] ptr
);

    // R4
    oe_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> !ev.scl);

    // R1
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (!sda_oe_o && fsm_state == ST_ADDR));

    // R1
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && !ev.start) |=> (fsm_state == ST_IDLE && !sda_oe_o));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fsm_state == ST_IDLE |-> !sda_oe_o);

    // R6
    we_single_chk: assert property (@(posedge clk) disable iff (rst)
        bus_we |=> !bus_we);

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bus_we |-> $stable(ptr));

    // R8
    hold_released_chk: assert property (@(posedge clk) disable iff (rst)
        fsm_state == ST_HOLD |-> !sda_oe_o);

endmodule

bind twi_ptr_slave twi_ptr_slave_chk #(
    .PTR_W(PTR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev),
    .sda_oe_o (sda_oe_o),
    .fsm_state(fsm_state),
    .bus_we   (bus_we),
    .ptr      (ptr)
);

// File: tb/twi_ptr_slave_tb.sv
module twi_ptr_slave_tb;

    localparam logic [6:0] DEV = 7'h4C;
    localparam int PW = 4;
    localparam int NREG = 1 << PW;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic ext_we = 1'b0;
    logic [PW-1:0] ext_addr = '0;
    logic [7:0] ext_wdata = '0;
    logic [7:0] ext_rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [NREG];
    logic high_glitch;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    twi_ptr_slave #(.DEV_ADDR(DEV), .PTR_W(PW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .ext_we_i(ext_we), .ext_addr_i(ext_addr), .ext_wdata_i(ext_wdata),
        .ext_rdata_o(ext_rdata)
    );

    function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
        return {a, rd};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq(input int n = Q);
        repeat (n) @(negedge clk);
    endtask

    task automatic b_start;
        sda_m = 1'b1; scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic b_rstart;
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic b_stop;
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic b_send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq();
            scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq(Q / 2);
        ack = (sda_line == 1'b0);
        wq(Q - Q / 2);
        scl_m = 1'b0; wq();
    endtask

    task automatic b_recv(input logic mack, output logic [7:0] b);
        logic first;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl_m = 1'b1; wq(1);
            first = sda_line;
            wq(Q / 2 - 1);
            b[i] = sda_line;
            wq(Q - Q / 2 - 1);
            if (sda_line !== first) high_glitch = 1'b1;
            wq(1);
            scl_m = 1'b0;
        end
        wq();
        sda_m = mack ? 1'b0 : 1'b1; wq();
        scl_m = 1'b1; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic ext_read(input logic [PW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        ext_addr = a;
        #1 d = ext_rdata;
    endtask

    task automatic ext_write(input logic [PW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ext_addr = a; ext_wdata = d; ext_we = 1'b1;
        @(negedge clk);
        ext_we = 1'b0;
        model[a] = d;
    endtask

    task automatic bus_write(input logic [PW-1:0] a, input logic [7:0] d);
        logic ack;
        b_start();
        b_send(addr_byte(DEV, 1'b0), ack);
        b_send({4'h0, a}, ack);
        b_send(d, ack);
        b_stop();
        model[a] = d;
    endtask

    task automatic bus_read(input logic [PW-1:0] a, output logic [7:0] d);
        logic ack;
        b_start();
        b_send(addr_byte(DEV, 1'b0), ack);
        b_send({4'h0, a}, ack);
        b_rstart();
        b_send(addr_byte(DEV, 1'b1), ack);
        b_recv(1'b0, d);
        b_stop();
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic ack, ack2, ack3;
        logic [7:0] d;
        int bad;
        void'($urandom(32'd20240611));
        high_glitch = 1'b0;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        wq();

        // R11 reset state
        check("R11 sda released", {7'd0, sda_oe}, 8'h00);
        bad = 0;
        for (int i = 0; i < NREG; i++) begin
            ext_read(PW'(i), d);
            if (d !== 8'h00) bad++;
        end
        check("R11 bank zero", 8'(bad), 8'h00);

        // R2 R5 R6 pointer plus data write
        b_start();
        b_send(addr_byte(DEV, 1'b0), ack);
        check("R2 address ack", {7'd0, ack}, 8'h01);
        b_send(8'h03, ack);
        check("R5 pointer ack", {7'd0, ack}, 8'h01);
        b_send(8'hA5, ack);
        check("R6 data ack", {7'd0, ack}, 8'h01);
        b_stop();
        check("R1 released after stop", {7'd0, sda_oe}, 8'h00);
        model[3] = 8'hA5;
        ext_read(4'd3, d);
        check("R6 R10 stored value", d, 8'hA5);

        // R8 R5 read from persistent pointer
        b_start();
        b_send(addr_byte(DEV, 1'b1), ack);
        check("R2 read address ack", {7'd0, ack}, 8'h01);
        b_recv(1'b0, d);
        b_stop();
        check("R8 R5 read keeps pointer", d, 8'hA5);

        // R5 R10 pointer-only write then direct-port value read over bus
        b_start();
        b_send(addr_byte(DEV, 1'b0), ack);
        b_send(8'h07, ack);
        b_stop();
        ext_write(4'd7, 8'h3C);
        b_start();
        b_send(addr_byte(DEV, 1'b1), ack);
        b_recv(1'b0, d);
        b_stop();
        check("R5 R10 pointer-only write", d, 8'h3C);

        // R7 third byte is NACKed and ignored
        b_start();
        b_send(addr_byte(DEV, 1'b0), ack);
        b_send(8'h02, ack);
        b_send(8'h11, ack2);
        b_send(8'h99, ack3);
        b_stop();
        model[2] = 8'h11;
        check("R7 extra byte nack", {7'd0, ack3}, 8'h00);
        ext_read(4'd2, d);
        check("R7 extra byte ignored", d, 8'h11);

        // R3 mismatched address
        b_start();
        b_send(addr_byte(DEV ^ 7'h01, 1'b0), ack);
        check("R3 no ack on mismatch", {7'd0, ack}, 8'h00);
        b_send(8'h05, ack);
        check("R3 later byte not acked", {7'd0, ack}, 8'h00);
        b_send(8'h77, ack);
        b_stop();
        ext_read(4'd5, d);
        check("R3 bank untouched", d, 8'h00);
        b_start();
        b_send(addr_byte(DEV, 1'b1), ack);
        b_recv(1'b0, d);
        b_stop();
        check("R3 pointer untouched", d, 8'h11);

        // R9 repeated start aborts write and restarts
        b_start();
        b_send(addr_byte(DEV, 1'b0), ack);
        b_send(8'h04, ack);
        b_rstart();
        b_send(addr_byte(DEV, 1'b0), ack);
        check("R9 ack after repeated start", {7'd0, ack}, 8'h01);
        b_send(8'h06, ack);
        b_send(8'h5A, ack);
        b_stop();
        model[6] = 8'h5A;
        ext_read(4'd6, d);
        check("R9 write after restart", d, 8'h5A);
        ext_read(4'd4, d);
        check("R9 aborted target untouched", d, 8'h00);

        // R9 pointer set then repeated start into read
        ext_write(4'd9, 8'hC3);
        bus_read(4'd9, d);
        check("R9 restart read", d, 8'hC3);

        // R8 master ACK then more clocks: slave stays released
        b_start();
        b_send(addr_byte(DEV, 1'b1), ack);
        b_recv(1'b1, d);
        check("R8 first byte", d, 8'hC3);
        b_recv(1'b0, d);
        b_stop();
        check("R8 released afterwards", d, 8'hFF);
        ext_read(4'd9, d);
        check("R9 read does not write", d, 8'hC3);

        // Random mixed traffic against the model
        for (int n = 0; n < 24; n++) begin
            logic [PW-1:0] a;
            logic [7:0] v;
            a = PW'($urandom_range(0, NREG - 1));
            v = 8'($urandom);
            if ($urandom_range(0, 3) == 0) ext_write(a, v);
            else bus_write(a, v);
            a = PW'($urandom_range(0, NREG - 1));
            bus_read(a, d);
            check("R6 R10 random readback", d, model[a]);
        end

        check("R4 SDA stable while SCL high", {7'd0, high_glitch}, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule